// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block is a two-wire management bus (SMBus) slave that serves a small byte-wide register file through indexed block transfers. SCL and SDA are oversampled in the system clock domain. SDA is an open-drain line, so the block only ever requests a low level through `sda_pull_o`. Two strap inputs place the slave at one of four bus addresses. The read/write registers go straight out to the rest of the chip. The read-only bytes return external pin levels and fixed identity codes.

A host writes by sending the write address, a starting index, a byte count and then that many data bytes. The slave acknowledges every byte it receives. A host reads by sending the write address and an index, then a repeated start and the read address. The slave answers with the content of the byte-count register, followed by registers from the index upward, until the host stops acknowledging. A stop or a start at any point abandons the transfer in progress.

The protocol engine is a single state machine with these states:

- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte. On a match it moves to `ST_ACK_WAIT`; otherwise it moves to `ST_IGNORE`.
- `ST_RX`: shifts in an index, count or data byte, then moves to `ST_ACK_WAIT`.
- `ST_ACK_WAIT`: waits for the falling SCL edge that ends the eighth bit, then moves to `ST_ACK`.
- `ST_ACK`: holds SDA low through the ninth clock. On the fall that ends it, the machine moves to `ST_TX` for a read or `ST_RX` for a write.
- `ST_TX`: shifts a byte out. After the eighth fall it moves to `ST_HACK`.
- `ST_HACK`: samples the host's acknowledge. An ACK leads to `ST_TX_NEXT`; a NACK leads to `ST_IGNORE`.
- `ST_TX_NEXT`: loads the next byte on the following fall and returns to `ST_TX`.
- `ST_IGNORE`: waits for the bus to end the transfer.

From any state, a start leads to `ST_ADDR` and a stop leads to `ST_IDLE`.

Top module: `smb_idx_regslave`

## Requirements
- R1: The slave acknowledges the 8-bit address 0xD4, 0xD6, 0xD8 or 0xDA when `strap_i` is 00, 01, 10 or 11 respectively (7-bit address 0x6A plus the strap value), and the same address with bit 0 set for reads. The slave does not acknowledge any other address and leaves SDA released until the next start.
- R2: In a write, the byte after the address is the index N and the next byte is the count X. The X data bytes that follow are stored in registers N to N+X-1. The address, index, count and data bytes are each acknowledged.
- R3: After the write address, an index N, a repeated start and the read address, the slave sends the byte-count register first and then registers N, N+1 and so on. It sends one register per host ACK and releases SDA after the host NACKs.
- R4: Register 7 is read/write, resets to 0x07, and its value appears on `blk_cnt_o`.
- R5: Register 5 reads 0x11 (revision 1 in bits 7:4, vendor 1 in bits 3:0). Register 6 reads 0x18. Writes do not change either register.
- R6: Register 3 reads `pin_grp_a_i`. Register 4 reads bits 7:6 as 0 and bits 5:0 as `pin_grp_b_i`. Both are sampled when the byte is loaded for sending.
- R7: Registers 1 and 2 are read/write, reset to 0xFF, and appear on `out_en_a_o` and `out_en_b_o`.
- R8: Writes to registers 3 to 6, to index 0 and to indices 8 and above are acknowledged and discarded. Reads of index 0 and of indices 8 and above return 0x00.
- R9: Data bytes beyond the count X are acknowledged and discarded.
- R10: A stop or a start in the middle of a byte abandons the transfer without writing that byte. The slave then serves the next transfer normally.
- R11: Bytes are sent and received MSB first. SDA is sampled on SCL rising edges, and the slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 requests the open-drain SDA driver to pull low |
| strap_i | input | 2 | Address strap, added to the base 7-bit address |
| pin_grp_a_i | input | 8 | Pin levels returned by register 3 |
| pin_grp_b_i | input | 6 | Pin levels returned by register 4 bits 5:0 |
| out_en_a_o | output | 8 | Register 1 contents |
| out_en_b_o | output | 8 | Register 2 contents |
| blk_cnt_o | output | 8 | Register 7 contents, the block-read count |

## Verification
The assertions assume the following about the bus inputs:

- SCL stays low and stays high for several system clocks on each phase.
- SDA changes only well inside the SCL low phase, except for the intentional start and stop edges.
- The host never pulls SDA while the slave sends a 0.

The bench is the only bus master. It moves SDA a quarter of a bit after each SCL fall and releases the line whenever the slave is due to drive. It also holds the strap and pin inputs steady during a transfer, changing them only between transfers.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 8;
    localparam int PIN_B_W = BYTE_W - 2;
    localparam int BIT_W   = 4;

    localparam logic [IDX_W-1:0] IDX_EN_A  = 8'd1;
    localparam logic [IDX_W-1:0] IDX_EN_B  = 8'd2;
    localparam logic [IDX_W-1:0] IDX_PIN_A = 8'd3;
    localparam logic [IDX_W-1:0] IDX_PIN_B = 8'd4;
    localparam logic [IDX_W-1:0] IDX_ID    = 8'd5;
    localparam logic [IDX_W-1:0] IDX_DEV   = 8'd6;
    localparam logic [IDX_W-1:0] IDX_CNT   = 8'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_HACK,
        ST_TX_NEXT,
        ST_IGNORE
    } smb_state_e;

    typedef enum logic [1:0] {
        ROLE_INDEX,
        ROLE_COUNT,
        ROLE_DATA
    } smb_role_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic             scl_q;
    logic             sda_q;

    assign raw = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= '1;
                end else begin
                    sh <= {sh[STAGES-2:0], raw[g]};
                end
            end
            assign lvl[g] = sh[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= lvl[0];
            sda_q <= lvl[1];
        end
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~scl_q;
    assign scl_fall  = ~lvl[0] & scl_q;
    assign start_det = lvl[0] & scl_q & sda_q & ~lvl[1];
    assign stop_det  = lvl[0] & scl_q & ~sda_q & lvl[1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter logic [3:0]        REV_ID  = 4'h1,
    parameter logic [3:0]        VEN_ID  = 4'h1,
    parameter logic [BYTE_W-1:0] DEV_ID  = 8'h18,
    parameter logic [BYTE_W-1:0] CNT_RST = 8'h07,
    parameter logic [BYTE_W-1:0] EN_RST  = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic [BYTE_W-1:0]  pin_a,
    input  logic [PIN_B_W-1:0] pin_b,
    output logic [BYTE_W-1:0]  en_a,
    output logic [BYTE_W-1:0]  en_b,
    output logic [BYTE_W-1:0]  blk_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a    <= EN_RST;
            en_b    <= EN_RST;
            blk_cnt <= CNT_RST;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_EN_A: en_a    <= wr_data;
                IDX_EN_B: en_b    <= wr_data;
                IDX_CNT:  blk_cnt <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_EN_A:  rd_data = en_a;
            IDX_EN_B:  rd_data = en_b;
            IDX_PIN_A: rd_data = pin_a;
            IDX_PIN_B: rd_data = {{(BYTE_W-PIN_B_W){1'b0}}, pin_b};
            IDX_ID:    rd_data = {REV_ID, VEN_ID};
            IDX_DEV:   rd_data = DEV_ID;
            IDX_CNT:   rd_data = blk_cnt;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR = 7'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] blk_cnt,
    output logic              sda_drv,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output smb_state_e        state_o
);
    smb_state_e        state, state_nx;
    smb_role_e         role;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] left;
    logic              rd_mode;
    logic [6:0]        my_addr;
    logic [BYTE_W-1:0] rx_byte;
    logic              bit_last;
    logic              addr_hit;

    assign my_addr  = BASE_ADDR + {5'b0, strap};
    assign rx_byte  = {rx_sh[BYTE_W-2:0], sda_lvl};
    assign bit_last = (bit_cnt == BIT_W'(BYTE_W - 1));
    assign addr_hit = (rx_byte[BYTE_W-1:1] == my_addr);

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     ;
                ST_ADDR:     if (scl_rise && bit_last) state_nx = addr_hit ? ST_ACK_WAIT : ST_IGNORE;
                ST_RX:       if (scl_rise && bit_last) state_nx = ST_ACK_WAIT;
                ST_ACK_WAIT: if (scl_fall) state_nx = ST_ACK;
                ST_ACK:      if (scl_fall) state_nx = rd_mode ? ST_TX : ST_RX;
                ST_TX:       if (scl_fall && bit_cnt == BIT_W'(BYTE_W)) state_nx = ST_HACK;
                ST_HACK:     if (scl_rise) state_nx = sda_lvl ? ST_IGNORE : ST_TX_NEXT;
                ST_TX_NEXT:  if (scl_fall) state_nx = ST_TX;
                ST_IGNORE:   ;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            role    <= ROLE_INDEX;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            idx     <= '0;
            left    <= '0;
            rd_mode <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                role    <= ROLE_INDEX;
            end else if (stop_det) begin
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_last) rd_mode <= sda_lvl;
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_last) begin
                                case (role)
                                    ROLE_INDEX: begin
                                        idx  <= rx_byte;
                                        role <= ROLE_COUNT;
                                    end
                                    ROLE_COUNT: begin
                                        left <= rx_byte;
                                        role <= ROLE_DATA;
                                    end
                                    default: begin
                                        if (left != '0) begin
                                            wr_en   <= 1'b1;
                                            wr_idx  <= idx;
                                            wr_data <= rx_byte;
                                            idx     <= idx + 1'b1;
                                            left    <= left - 1'b1;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) tx_sh <= blk_cnt;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt != BIT_W'(BYTE_W)) begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_TX_NEXT: begin
                        if (scl_fall) begin
                            tx_sh   <= rd_data;
                            idx     <= idx + 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ACK:  sda_drv = 1'b1;
            ST_TX:   sda_drv = ~tx_sh[BYTE_W-1];
            default: sda_drv = 1'b0;
        endcase
    end

    assign rd_idx  = idx;
    assign state_o = state;
endmodule

// File: rtl/smb_idx_regslave.sv
module smb_idx_regslave
    import smb_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] BASE_ADDR   = 7'h6A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [1:0]         strap_i,
    input  logic [BYTE_W-1:0]  pin_grp_a_i,
    input  logic [PIN_B_W-1:0] pin_grp_b_i,
    output logic [BYTE_W-1:0]  out_en_a_o,
    output logic [BYTE_W-1:0]  out_en_b_o,
    output logic [BYTE_W-1:0]  blk_cnt_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;
    smb_state_e        fsm_state;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_proto_fsm #(.BASE_ADDR(BASE_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .strap     (strap_i),
        .rd_data   (rd_data),
        .blk_cnt   (blk_cnt_o),
        .sda_drv   (sda_pull_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .state_o   (fsm_state)
    );

    smb_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .pin_a   (pin_grp_a_i),
        .pin_b   (pin_grp_b_i),
        .en_a    (out_en_a_o),
        .en_b    (out_en_b_o),
        .blk_cnt (blk_cnt_o)
    );
endmodule

// File: rtl/smb_chk.sv
module smb_chk
    import smb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              sda_drv,
    input logic              scl_rise,
    input logic              stop_det,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [BYTE_W-1:0] en_a,
    input logic [BYTE_W-1:0] en_b,
    input logic [BYTE_W-1:0] blk_cnt,
    input smb_state_e        state
);
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drv) |-> !scl_lvl); // R11

    AST_WRITE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_rise)); // R2

    AST_RO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_EN_A && wr_idx != IDX_EN_B && wr_idx != IDX_CNT)
        |=> ($stable(en_a) && $stable(en_b) && $stable(blk_cnt))); // R8

    AST_EN_A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_a) |-> $past(wr_en && wr_idx == IDX_EN_A)); // R7

    AST_EN_B_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_b) |-> $past(wr_en && wr_idx == IDX_EN_B)); // R7

    AST_CNT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk_cnt) |-> $past(wr_en && wr_idx == IDX_CNT)); // R4

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_drv && state == ST_IDLE)); // R10
endmodule

bind smb_idx_regslave smb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_drv  (sda_pull_o),
    .scl_rise (scl_rise),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .en_a     (out_en_a_o),
    .en_b     (out_en_b_o),
    .blk_cnt  (blk_cnt_o),
    .state    (fsm_state)
);

// File: tb/smb_idx_regslave_tb.sv
module smb_idx_regslave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_line;
    logic       sda_pull;
    logic [1:0] strap = 2'd0;
    logic [7:0] pin_a = 8'hA5;
    logic [5:0] pin_b = 6'h2C;
    logic [7:0] en_a, en_b, bcnt;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] exp_a = 8'hFF;
    logic [7:0] exp_b = 8'hFF;
    logic [7:0] exp_c = 8'h07;

    assign sda_line = ~(host_low | sda_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_idx_regslave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .strap_i     (strap),
        .pin_grp_a_i (pin_a),
        .pin_grp_b_i (pin_b),
        .out_en_a_o  (en_a),
        .out_en_b_o  (en_b),
        .blk_cnt_o   (bcnt)
    );

    function automatic logic [7:0] model(input int i);
        case (i)
            1: return exp_a;
            2: return exp_b;
            3: return pin_a;
            4: return {2'b00, pin_b};
            5: return 8'h11;
            6: return 8'h18;
            7: return exp_c;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            1, 2: return "R7";
            3, 4: return "R6";
            5, 6: return "R5";
            7: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        host_low = 1'b0; wq();
        scl = 1'b1; wq();
        host_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        host_low = 1'b1; wq();
        scl = 1'b1; wq();
        host_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        host_low = ~b; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        logic s1;
        host_low = 1'b0; wq();
        scl = 1'b1;
        repeat (5) @(negedge clk);
        s1 = sda_line;
        repeat (10) @(negedge clk);
        b = sda_line;
        chk("R11 sda stable while scl high", {7'b0, b}, {7'b0, s1});
        repeat (5) @(negedge clk);
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int k = 7; k >= 0; k--) send_bit(d[k]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int k = 7; k >= 0; k--) begin
            recv_bit(b);
            d[k] = b;
        end
        send_bit(~ack);
    endtask

    task automatic wr_block(input logic [6:0] a7, input int idx, input int cnt,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] dv;
        do_start();
        send_byte({a7, 1'b0}, ack); chk("R2 addr ack", {7'b0, ack}, 8'd1);
        send_byte(8'(idx), ack);    chk("R2 index ack", {7'b0, ack}, 8'd1);
        send_byte(8'(cnt), ack);    chk("R2 count ack", {7'b0, ack}, 8'd1);
        for (int k = 0; k < cnt; k++) begin
            dv = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
            send_byte(dv, ack); chk("R2 data ack", {7'b0, ack}, 8'd1);
        end
        do_stop();
    endtask

    task automatic rd_block(input logic [6:0] a7, input int idx, input int nbytes);
        logic ack;
        logic [7:0] d;
        do_start();
        send_byte({a7, 1'b0}, ack); chk("R3 addr ack", {7'b0, ack}, 8'd1);
        send_byte(8'(idx), ack);    chk("R3 index ack", {7'b0, ack}, 8'd1);
        do_start();
        send_byte({a7, 1'b1}, ack); chk("R1 read addr ack", {7'b0, ack}, 8'd1);
        recv_byte(d, 1'b1);         chk("R3 count byte first", d, exp_c);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(d, k != nbytes - 1);
            chk(tag_of(idx + k), d, model(idx + k));
        end
        chk("R3 released after nack", {7'b0, sda_pull}, 8'd0);
        do_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 reset en_a", en_a, 8'hFF);
        chk("R7 reset en_b", en_b, 8'hFF);
        chk("R4 reset count", bcnt, 8'h07);
        chk("R11 reset released", {7'b0, sda_pull}, 8'd0);

        // R1: every strap against every candidate address
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 4; a++) begin
                do_start();
                send_byte({7'(7'h6A + a), 1'b0}, ack);
                chk($sformatf("R1 strap %0d addr %0d", s, a), {7'b0, ack}, {7'b0, a == s});
                do_stop();
            end
            do_start();
            send_byte({7'(7'h68 + 6 * (s & 1)), 1'b0}, ack);
            chk("R1 outside address", {7'b0, ack}, 8'd0);
            chk("R1 no drive after miss", {7'b0, sda_pull}, 8'd0);
            do_stop();
        end

        strap = 2'd1;
        // R2 / R7: two-byte write to registers 1 and 2
        wr_block(7'h6B, 1, 2, 8'h5A, 8'hC3, 8'h00);
        exp_a = 8'h5A; exp_b = 8'hC3;
        chk("R7 en_a written", en_a, exp_a);
        chk("R7 en_b written", en_b, exp_b);

        // R4: count register write
        wr_block(7'h6B, 7, 1, 8'h03, 8'h00, 8'h00);
        exp_c = 8'h03;
        chk("R4 count written", bcnt, exp_c);

        // R8 / R5: writes to read-only and unimplemented indices
        wr_block(7'h6B, 4, 3, 8'hFF, 8'h00, 8'h77);
        wr_block(7'h6B, 0, 1, 8'h99, 8'h00, 8'h00);
        wr_block(7'h6B, 9, 2, 8'h44, 8'h55, 8'h00);
        chk("R8 outputs untouched a", en_a, exp_a);
        chk("R8 outputs untouched b", en_b, exp_b);
        chk("R8 outputs untouched c", bcnt, exp_c);

        // R9: byte beyond the count
        do_start();
        send_byte(8'hD6, ack); send_byte(8'd1, ack); send_byte(8'd1, ack);
        send_byte(8'h11, ack); chk("R9 counted byte ack", {7'b0, ack}, 8'd1);
        send_byte(8'h22, ack); chk("R9 extra byte ack", {7'b0, ack}, 8'd1);
        do_stop();
        exp_a = 8'h11;
        chk("R9 only counted byte stored a", en_a, exp_a);
        chk("R9 extra byte discarded b", en_b, exp_b);

        // R10: stop in mid-byte
        do_start();
        send_byte(8'hD6, ack); send_byte(8'd2, ack); send_byte(8'd1, ack);
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        do_stop();
        chk("R10 stop abort keeps en_b", en_b, exp_b);
        // R10: start in mid-byte, then a normal write
        do_start();
        send_byte(8'hD6, ack); send_byte(8'd2, ack); send_byte(8'd1, ack);
        for (int k = 0; k < 3; k++) send_bit(1'b0);
        do_start();
        send_byte(8'hD6, ack); chk("R10 address after restart", {7'b0, ack}, 8'd1);
        send_byte(8'd2, ack); send_byte(8'd1, ack); send_byte(8'h3C, ack);
        do_stop();
        exp_b = 8'h3C;
        chk("R10 write after abort", en_b, exp_b);

        // R3 / R5 / R6 / R8: single reads of indices 0 to 9
        for (int i = 0; i < 10; i++) rd_block(7'h6B, i, 1);
        pin_a = 8'h3E; pin_b = 6'h13;
        rd_block(7'h6B, 3, 2);
        // R3: block read with auto-increment under another strap
        strap = 2'd3;
        rd_block(7'h6D, 1, 7);
        rd_block(7'h6D, 254, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule